// File: doc/BRIEF.md
# MDIO Management Master Controller

This block lets a processor run Clause 22 management transactions on an MDC/MDIO pair towards external PHYs. Software writes one 32-bit command word that carries a valid flag, an operation selector, the PHY address, the register address and (for writes) 16 bits of data. The controller holds the command as pending until its serial engine is free. The engine then takes it and shifts the whole frame out. For a read, it releases MDIO and shifts the PHY's answer in.

A status register shows the two stages separately: a command that is accepted but not yet started, and a frame that is being shifted. A data register returns the last read value together with two error flags. MDC is derived from the system clock by a fixed divider. MDIO changes on the falling edge of MDC and is sampled on the rising edge. The usual software sequence is: poll until pending is clear, write the command, and for a read poll until busy is clear and then read the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset, status reads 0, MDC is low, MDIO is released (output enable low) and no frame is sent.
- R2: A command write to byte offset 0x8 that has bit 31 set and exactly one of bit 1 (write) or bit 2 (read) set is accepted. Pending (status bit 2) is set in the next cycle. When the engine takes the command, pending clears and busy (status bit 3) sets in the same cycle.
- R3: A write frame is 32 ones, then 01, then 01, then the PHY address (command bits 29:25), then the register address (command bits 24:20), then 10, then the data (command bits 19:4). Every field is sent MSB first, and MDIO is driven for all 64 bits.
- R4: A read frame uses opcode 10. MDIO is driven for the first 46 bits and released from the first turnaround bit through the last data bit. The 16 data bits are returned in data register bits 15:0 (byte offset 0xC).
- R5: If the PHY does not drive the second turnaround bit low on a read, data register bit 16 is set.
- R6: If all 16 read data bits arrive as ones, data register bit 17 is set.
- R7: A command written while pending is set is ignored. The frame sent is the earlier command, and no second frame follows.
- R8: A command write that has bit 31 clear, or that has neither or both of bits 1 and 2 set, is ignored, and pending stays clear.
- R9: Both error flags clear when the next read frame starts.
- R10: MDC has a period of 2*DIV_HALF system clocks, and MDIO output changes only in the cycle in which MDC falls.
- R11: Busy clears after the final bit of the frame, and MDIO is released whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the address from the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high means the block drives the line) |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or a wrong shift register shows up as a misplaced or corrupted field in the captured 64-bit frame within one MDC period of the fault. A wrong turn of the drive-enable state appears as MDIO being driven during the turnaround, or still being driven after busy falls. A fault in pending or busy handling shows in the status register within one MDC period: a frame that is never taken, a duplicated frame, or a second command that overwrites the first. Errors in the read path show as wrong data or wrong error flags when the data register is read after busy clears.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int CMD_VALID = 31;
  localparam int CMD_WR    = 1;
  localparam int CMD_RD    = 2;
  localparam int PHY_LSB   = 25;
  localparam int REG_LSB   = 20;
  localparam int WD_LSB    = 4;
  localparam int ST_PEND   = 2;
  localparam int ST_BUSY   = 3;

  typedef struct packed {
    logic        is_rd;
    logic [4:0]  phy;
    logic [4:0]  regno;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(DIV_HALF - 1));
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_MIN_HALF: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |=> $stable(mdc)); // R10
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        start_req,
  input  mdio_cmd_t   cmd,
  input  logic        mdio_i,
  output logic        take,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output logic        ta_err,
  output logic        ones_err
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] frame;
  logic [FRAME_LEN-1:0] sh;
  logic [IW-1:0]        idx;
  logic [IW-1:0]        idx_nx;
  logic                 rd_op;

  assign frame = {32'hFFFF_FFFF, 2'b01,
                  cmd.is_rd ? 2'b10 : 2'b01,
                  cmd.phy, cmd.regno,
                  cmd.is_rd ? 2'b11 : 2'b10,
                  cmd.is_rd ? 16'hFFFF : cmd.wdata};
  assign take   = fall_tick && !busy && start_req;
  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      sh       <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_op    <= 1'b0;
      rd_data  <= '0;
      ta_err   <= 1'b0;
      ones_err <= 1'b0;
    end else begin
      if (take) begin
        busy    <= 1'b1;
        idx     <= '0;
        sh      <= frame << 1;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
        rd_op   <= cmd.is_rd;
        if (cmd.is_rd) begin
          ta_err   <= 1'b0;
          ones_err <= 1'b0;
          rd_data  <= '0;
        end
      end else if (fall_tick && busy) begin
        if (idx == IW'(FRAME_LEN - 1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          if (rd_op) ones_err <= &rd_data;
        end else begin
          idx     <= idx_nx;
          mdio_o  <= sh[FRAME_LEN-1];
          sh      <= sh << 1;
          mdio_oe <= !(rd_op && (idx_nx >= IW'(TA_IDX)));
        end
      end
      if (rise_tick && busy && rd_op) begin
        if (idx == IW'(TA_IDX + 1)) ta_err <= mdio_i;
        if (idx >= IW'(DATA_IDX)) rd_data <= {rd_data[14:0], mdio_i};
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R11
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_op && (idx >= IW'(TA_IDX))) |-> !mdio_oe); // R4
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(4'hC);

  logic        rise_tick, fall_tick, take, busy, pending;
  logic        ta_err, ones_err, accept;
  logic [15:0] rd_data;
  mdio_cmd_t   cmd_q;
  logic [31:0] rmux;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start_req(pending), .cmd(cmd_q), .mdio_i(mdio_i), .take(take),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data),
    .ta_err(ta_err), .ones_err(ones_err)
  );

  assign accept = bus_wr && (bus_addr == A_CMD) && bus_wdata[CMD_VALID] &&
                  (bus_wdata[CMD_WR] ^ bus_wdata[CMD_RD]) && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cmd_q   <= '0;
    end else if (accept) begin
      pending     <= 1'b1;
      cmd_q.is_rd <= bus_wdata[CMD_RD];
      cmd_q.phy   <= bus_wdata[PHY_LSB +: 5];
      cmd_q.regno <= bus_wdata[REG_LSB +: 5];
      cmd_q.wdata <= bus_wdata[WD_LSB +: 16];
    end else if (take) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == A_STATUS) begin
      rmux[ST_PEND] = pending;
      rmux[ST_BUSY] = busy;
    end else if (bus_addr == A_DATA) begin
      rmux = {14'b0, ones_err, ta_err, rd_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rmux;
  end

  AST_PEND_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> busy); // R2
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (pending && !take) |=> $stable(cmd_q)); // R7
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc)); // R10
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int DIVH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  logic        cap_clear = 1'b0;
  logic        started = 1'b0;
  int          n = 0;
  int          extra = 0;
  logic [63:0] capo, capoe;
  logic [15:0] phy_val = 16'h0000;
  logic        ta2 = 1'b0;

  always #2 clk = !clk;

  mdio_master #(.DIV_HALF(DIVH), .ADDR_W(4)) u_mdio_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (cap_clear) begin
      started = 1'b0; n = 0; extra = 0; capo = '0; capoe = '0;
    end else if (started || mdio_oe) begin
      started = 1'b1;
      if (n < 64) begin
        capo[n]  = mdio_o;
        capoe[n] = mdio_oe;
        n = n + 1;
      end else if (mdio_oe) begin
        extra = extra + 1;
      end
    end
  end

  always @(negedge mdc) begin
    if (started && n == 47)                mdio_i = ta2;
    else if (started && n >= 48 && n < 64) mdio_i = phy_val[63-n];
    else                                   mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic clear_capture();
    cap_clear = 1'b1;
    repeat (2) @(posedge mdc);
    @(negedge clk);
    cap_clear = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_read(4'h0, s);
      if (s[3:2] == 2'b00) break;
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] p,
                                         input logic [4:0] r, input logic [15:0] d);
    return {1'b1, 1'b0, p, r, d, 1'b0, rd, !rd, 1'b0};
  endfunction

  function automatic logic [63:0] exp_write(input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic bit frame_match(input logic [63:0] e, input int cnt);
    for (int k = 0; k < cnt; k++) if (capo[k] !== e[63-k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    logic [31:0] s;
    bus_read(4'h0, s);
    check(s == 32'h0, "R1 status after reset", s, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_mdc_period();
    time t0, t1;
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check((t1 - t0) == 2 * DIVH * 4, "R10 mdc period ns", t1 - t0, 2 * DIVH * 4);
  endtask

  task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [31:0] s;
    clear_capture();
    bus_write(4'h8, mk_cmd(1'b0, p, r, d));
    bus_read(4'h0, s);
    check(s[2] == 1'b1 && s[3] == 1'b0, "R2 pending set, busy clear", s, 4);
    @(posedge mdc); @(negedge clk);
    bus_read(4'h0, s);
    check(s[3:2] == 2'b10, "R2 busy set, pending clear", s, 8);
    wait_idle();
    repeat (2) @(posedge mdc);
    check(n == 64 && frame_match(exp_write(p, r, d), 64), "R3 write frame",
          capo, exp_write(p, r, d));
    check(capoe == 64'hFFFF_FFFF_FFFF_FFFF, "R3 driven whole frame", capoe, 64'hFFFF_FFFF_FFFF_FFFF);
    check(mdio_oe == 1'b0, "R11 released after frame", mdio_oe, 0);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v,
                        input logic t2, input logic [1:0] eflags, input string tag);
    logic [31:0] s;
    logic [63:0] e;
    phy_val = v; ta2 = t2;
    clear_capture();
    bus_write(4'h8, mk_cmd(1'b1, p, r, 16'h0));
    wait_idle();
    @(posedge mdc);
    e = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
    check(frame_match(e, 46), {tag, " read header"}, capo[45:0], 0);
    check(capoe[45:0] == {46{1'b1}} && capoe[63:46] == '0, {tag, " R4 oe pattern"},
          capoe, {18'h0, {46{1'b1}}});
    bus_read(4'hC, s);
    check(s == {14'h0, eflags, v}, {tag, " data reg"}, s, {14'h0, eflags, v});
  endtask

  task automatic t_ignore_pending();
    logic [31:0] s;
    clear_capture();
    bus_write(4'h8, mk_cmd(1'b0, 5'h0A, 5'h15, 16'h5A5A));
    bus_write(4'h8, mk_cmd(1'b0, 5'h1F, 5'h00, 16'hFFFF));
    wait_idle();
    repeat (12) @(posedge mdc);
    bus_read(4'h0, s);
    check(s[3:2] == 2'b00, "R7 no second command queued", s, 0);
    check(frame_match(exp_write(5'h0A, 5'h15, 16'h5A5A), 64), "R7 first command sent",
          capo, exp_write(5'h0A, 5'h15, 16'h5A5A));
    check(extra == 0, "R7 no second frame", extra, 0);
  endtask

  task automatic t_invalid();
    logic [31:0] s;
    clear_capture();
    bus_write(4'h8, mk_cmd(1'b0, 5'h1, 5'h1, 16'h1) & 32'h7FFF_FFFF);
    bus_read(4'h0, s);
    check(s[2] == 1'b0, "R8 valid bit clear ignored", s, 0);
    bus_write(4'h8, 32'h8000_0000 | (32'h3 << 25));
    bus_read(4'h0, s);
    check(s[2] == 1'b0, "R8 no operation ignored", s, 0);
    bus_write(4'h8, 32'h8000_0006);
    bus_read(4'h0, s);
    check(s[2] == 1'b0, "R8 both operations ignored", s, 0);
    repeat (3) @(posedge mdc);
    check(started == 1'b0, "R8 no frame sent", started, 0);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mdc_period();
    t_write(5'h13, 5'h0A, 16'hA5C3);
    t_write(5'h00, 5'h1F, 16'h0001);
    t_read(5'h01, 5'h02, 16'h1234, 1'b0, 2'b00, "R4 good");
    t_read(5'h1E, 5'h11, 16'h8001, 1'b1, 2'b01, "R5 ta error");
    t_read(5'h05, 5'h06, 16'hFFFF, 1'b0, 2'b10, "R6 all ones");
    t_read(5'h07, 5'h03, 16'h0F0F, 1'b0, 2'b00, "R9 flags cleared");
    t_ignore_pending();
    t_invalid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule